// File: doc/BRIEF.md
# Two-Level Address Translation Lookup

This block turns virtual addresses into physical addresses for a processor that has separate instruction and data request streams. Each stream has its own small first-level table of recently used single pages. Behind both sits one larger shared table that is fully associative. Each entry of the shared table carries a single tag that covers an aligned pair of neighbouring pages, with a separate frame number and valid bit for the even page and for the odd page. Pages are 4 KB. An address is split into a 20-bit virtual page number and a 12-bit offset. The page offset passes through unchanged.

A request that hits its first-level table is answered in the same cycle. If it misses there, the block stalls the requester for one cycle while it searches the shared table. On a hit, the page is copied into that side's first-level table, and the translation appears in the following cycle. On a miss, the block raises a miss exception instead. The one exception to this is a data-side prefetch: it never traps, and when it cannot be translated it simply completes with nothing. Software fills the shared table through a write port and can clear the whole hierarchy with a single invalidate input. Both of these actions empty the first-level tables, so no stale copy of a mapping can be used.

Top module: `tlb_cascade`

## Requirements
- R1: When a side's first-level table holds a valid entry whose page number (va[31:12]) and address-space ID both match the request, that side shows hit=1, stall=0 and miss=0 in the same cycle, with pa = {frame, va[11:0]}. Whenever hit is 0, pa is zero.
- R2: When a request misses its first-level table, stall is 1 for that cycle. If the shared table then hits, the next cycle shows hit=1 with the translated pa, and the page is now in that side's first-level table, so a later identical request hits with no stall.
- R3: A shared-table entry matches when its tag equals va[31:13], its ID equals the request ID, and the valid bit of the half chosen by va[12] is set (0 = even half, 1 = odd half). The frame number comes from that same half. If several entries qualify, the lowest index wins.
- R4: If no shared-table entry qualifies, the request stalls for one cycle and then shows miss=1 with hit=0 and stall=0 while the request is still held.
- R5: A data request with the prefetch flag set never raises miss. If it cannot be translated, it stalls once and then shows hit, stall and miss all at 0. If it can be translated, it behaves as in R1 and R2.
- R6: Each first-level table has 3 entries. Refills go to the slots in round-robin order, so when a 4th distinct page is filled, the page that was filled first is evicted.
- R7: The two first-level tables are separate. A refill on one side does not create a hit on the other side.
- R8: When both sides need the shared table in the same cycle, the data side is searched first and gets its result one cycle later. The instruction side stays stalled for one more cycle and gets its result one cycle after the data side.
- R9: A write (jw_en) stores the tag, ID, both frames and both valid bits at index jw_idx on the clock edge. The same write empties both first-level tables, so in the next cycle neither side can hit there.
- R10: The invalidate input clears every valid bit in the shared table and in both first-level tables. A write in the same cycle still installs its entry.
- R11: After reset, every table is empty. With no request, every output is 0, and the first lookup after reset ends in a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_req | input | 1 | Instruction lookup request |
| i_va | input | 32 | Instruction virtual address |
| i_asid | input | 8 | Instruction address-space ID |
| i_pa | output | 32 | Instruction physical address, zero unless hit |
| i_hit | output | 1 | Instruction translation valid |
| i_stall | output | 1 | Instruction side waiting on shared table |
| i_miss | output | 1 | Instruction miss exception |
| d_req | input | 1 | Data lookup request |
| d_va | input | 32 | Data virtual address |
| d_asid | input | 8 | Data address-space ID |
| d_pref | input | 1 | Data request is a prefetch |
| d_pa | output | 32 | Data physical address, zero unless hit |
| d_hit | output | 1 | Data translation valid |
| d_stall | output | 1 | Data side waiting on shared table |
| d_miss | output | 1 | Data miss exception |
| jw_en | input | 1 | Shared-table write strobe |
| jw_idx | input | 4 | Shared-table entry index |
| jw_vpn2 | input | 19 | Tag: virtual page-pair number |
| jw_asid | input | 8 | Tag: address-space ID |
| jw_pfn0 | input | 20 | Even-page frame number |
| jw_v0 | input | 1 | Even-page valid |
| jw_pfn1 | input | 20 | Odd-page frame number |
| jw_v1 | input | 1 | Odd-page valid |
| inval_all | input | 1 | Invalidate every table |

## Verification
The assertions assume that a requester holds its request, address, ID and prefetch flag steady for as long as its stall output is high, and for the one following cycle in which the result is shown. Because of this, the checks that look back over a stall condition on the address and ID being stable and on no write or invalidate having occurred in between. The bench always drives a request on a falling edge and keeps it unchanged until its outcome has been sampled. It releases the request only after that. Writes and invalidates are issued only between requests, with one exception: a directed case of a write that lands in the same cycle as an invalidate.

// File: rtl/tlb_cascade.sv
module tlb_cascade #(
  parameter int VA_W   = 32,
  parameter int PG_W   = 12,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int UT_N   = 3,
  parameter int JT_N   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          i_req,
  input  logic [VA_W-1:0]               i_va,
  input  logic [ASID_W-1:0]             i_asid,
  output logic [PPN_W+PG_W-1:0]         i_pa,
  output logic                          i_hit,
  output logic                          i_stall,
  output logic                          i_miss,
  input  logic                          d_req,
  input  logic [VA_W-1:0]               d_va,
  input  logic [ASID_W-1:0]             d_asid,
  input  logic                          d_pref,
  output logic [PPN_W+PG_W-1:0]         d_pa,
  output logic                          d_hit,
  output logic                          d_stall,
  output logic                          d_miss,
  input  logic                          jw_en,
  input  logic [$clog2(JT_N)-1:0]       jw_idx,
  input  logic [VA_W-PG_W-2:0]          jw_vpn2,
  input  logic [ASID_W-1:0]             jw_asid,
  input  logic [PPN_W-1:0]              jw_pfn0,
  input  logic                          jw_v0,
  input  logic [PPN_W-1:0]              jw_pfn1,
  input  logic                          jw_v1,
  input  logic                          inval_all
);
  localparam int VPN_W  = VA_W - PG_W;
  localparam int VPN2_W = VPN_W - 1;
  localparam int UIX_W  = (UT_N > 1) ? $clog2(UT_N) : 1;

  logic [VA_W-1:0]   s_va   [2];
  logic [ASID_W-1:0] s_asid [2];
  logic [1:0]        s_req;

  assign s_va[0]   = i_va;
  assign s_va[1]   = d_va;
  assign s_asid[0] = i_asid;
  assign s_asid[1] = d_asid;
  assign s_req     = {d_req, i_req};

  logic [VPN_W-1:0]  u_vpn  [2][UT_N];
  logic [ASID_W-1:0] u_asid [2][UT_N];
  logic [PPN_W-1:0]  u_ppn  [2][UT_N];
  logic [UT_N-1:0]   u_v    [2];
  logic [UIX_W-1:0]  u_rr   [2];

  logic [VPN2_W-1:0] j_vpn2 [JT_N];
  logic [ASID_W-1:0] j_asid [JT_N];
  logic [PPN_W-1:0]  j_pfn0 [JT_N];
  logic [PPN_W-1:0]  j_pfn1 [JT_N];
  logic [JT_N-1:0]   j_v0, j_v1;

  logic [1:0]        pend_miss, uhit, need_j, grant;
  logic [PPN_W-1:0]  uppn [2];
  logic [VA_W-1:0]   q_va;
  logic [ASID_W-1:0] q_asid;
  logic              q_odd, jhit, flush;
  logic [PPN_W-1:0]  jppn;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      uhit[s] = 1'b0;
      uppn[s] = '0;
      for (int e = 0; e < UT_N; e++) begin
        if (u_v[s][e] && u_vpn[s][e] == s_va[s][VA_W-1:PG_W] &&
            u_asid[s][e] == s_asid[s]) begin
          uhit[s] = 1'b1;
          uppn[s] = u_ppn[s][e];
        end
      end
    end
  end

  assign need_j = s_req & ~uhit & ~pend_miss;
  assign grant  = {need_j[1], need_j[0] & ~need_j[1]};
  assign q_va   = grant[1] ? d_va : i_va;
  assign q_asid = grant[1] ? d_asid : i_asid;
  assign q_odd  = q_va[PG_W];
  assign flush  = jw_en | inval_all;

  always_comb begin
    jhit = 1'b0;
    jppn = '0;
    for (int k = 0; k < JT_N; k++) begin
      if (!jhit && j_vpn2[k] == q_va[VA_W-1:PG_W+1] && j_asid[k] == q_asid &&
          (q_odd ? j_v1[k] : j_v0[k])) begin
        jhit = 1'b1;
        jppn = q_odd ? j_pfn1[k] : j_pfn0[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_miss <= '0;
      j_v0      <= '0;
      j_v1      <= '0;
      for (int s = 0; s < 2; s++) begin
        u_v[s]  <= '0;
        u_rr[s] <= '0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        pend_miss[s] <= grant[s] & ~jhit & ~flush;
        if (flush) begin
          u_v[s] <= '0;
        end else if (grant[s] && jhit) begin
          u_v[s][u_rr[s]] <= 1'b1;
          u_rr[s] <= (u_rr[s] == UIX_W'(UT_N - 1)) ? '0 : u_rr[s] + UIX_W'(1);
        end
      end
      if (inval_all) begin
        j_v0 <= '0;
        j_v1 <= '0;
      end
      if (jw_en) begin
        j_v0[jw_idx] <= jw_v0;
        j_v1[jw_idx] <= jw_v1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (!flush && grant[s] && jhit) begin
        u_vpn[s][u_rr[s]]  <= s_va[s][VA_W-1:PG_W];
        u_asid[s][u_rr[s]] <= s_asid[s];
        u_ppn[s][u_rr[s]]  <= jppn;
      end
    end
    if (jw_en) begin
      j_vpn2[jw_idx] <= jw_vpn2;
      j_asid[jw_idx] <= jw_asid;
      j_pfn0[jw_idx] <= jw_pfn0;
      j_pfn1[jw_idx] <= jw_pfn1;
    end
  end

  assign i_hit   = i_req & uhit[0];
  assign i_pa    = i_hit ? {uppn[0], i_va[PG_W-1:0]} : '0;
  assign i_stall = need_j[0];
  assign i_miss  = i_req & ~uhit[0] & pend_miss[0];

  assign d_hit   = d_req & uhit[1];
  assign d_pa    = d_hit ? {uppn[1], d_va[PG_W-1:0]} : '0;
  assign d_stall = need_j[1];
  assign d_miss  = d_req & ~uhit[1] & pend_miss[1] & ~d_pref;
endmodule

// File: rtl/tlb_cascade_chk.sv
module tlb_cascade_chk #(
  parameter int VA_W   = 32,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_req,
  input logic              i_hit,
  input logic              i_stall,
  input logic              i_miss,
  input logic              d_req,
  input logic [VA_W-1:0]   d_va,
  input logic [ASID_W-1:0] d_asid,
  input logic              d_pref,
  input logic              d_hit,
  input logic              d_stall,
  input logic              d_miss,
  input logic              jw_en,
  input logic              inval_all
);
  a_r1_hit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((i_hit && (i_stall || i_miss)) || (d_hit && (d_stall || d_miss))));

  a_r4_miss_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (i_miss |-> $past(i_stall)) and (d_miss |-> $past(d_stall)));

  a_r2_data_one_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && $past(rst_n) && $past(d_stall && !jw_en && !inval_all) &&
     $stable(d_va) && $stable(d_asid)) |-> !d_stall);

  a_r5_pref_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && d_pref && $past(rst_n) && $past(d_stall && d_pref) &&
     $stable(d_va) && $stable(d_asid)) |-> !d_miss);

  a_r8_instr_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (d_stall && i_stall) |=> (i_stall || !i_req));

  a_r9_flush_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (jw_en || inval_all) |=> (!i_hit && !d_hit));
endmodule

bind tlb_cascade tlb_cascade_chk #(.VA_W(VA_W), .ASID_W(ASID_W)) u_chk (.*);

// File: tb/tlb_cascade_bench.sv
module tlb_cascade_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        i_req, d_req, d_pref, jw_en, jw_v0, jw_v1, inval_all;
  logic [31:0] i_va, d_va, i_pa, d_pa;
  logic [7:0]  i_asid, d_asid, jw_asid;
  logic        i_hit, i_stall, i_miss, d_hit, d_stall, d_miss;
  logic [3:0]  jw_idx;
  logic [18:0] jw_vpn2;
  logic [19:0] jw_pfn0, jw_pfn1;

  tlb_cascade u_tlb_cascade (
    .clk(clk), .rst_n(rst_n),
    .i_req(i_req), .i_va(i_va), .i_asid(i_asid), .i_pa(i_pa),
    .i_hit(i_hit), .i_stall(i_stall), .i_miss(i_miss),
    .d_req(d_req), .d_va(d_va), .d_asid(d_asid), .d_pref(d_pref), .d_pa(d_pa),
    .d_hit(d_hit), .d_stall(d_stall), .d_miss(d_miss),
    .jw_en(jw_en), .jw_idx(jw_idx), .jw_vpn2(jw_vpn2), .jw_asid(jw_asid),
    .jw_pfn0(jw_pfn0), .jw_v0(jw_v0), .jw_pfn1(jw_pfn1), .jw_v1(jw_v1),
    .inval_all(inval_all)
  );

  bit [18:0] m_vpn2 [16];
  bit [7:0]  m_asid [16];
  bit [19:0] m_p0 [16];
  bit [19:0] m_p1 [16];
  bit        m_v0 [16];
  bit        m_v1 [16];
  bit [19:0] mu_vpn [2][3];
  bit [7:0]  mu_asid [2][3];
  bit [19:0] mu_ppn [2][3];
  bit        mu_v [2][3];
  int        mu_rr [2];
  int        errs = 0;
  int        checks = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [20:0] j_look(bit [31:0] va, bit [7:0] asid);
    for (int k = 0; k < 16; k++)
      if (m_vpn2[k] == va[31:13] && m_asid[k] == asid && (va[12] ? m_v1[k] : m_v0[k]))
        return {1'b1, va[12] ? m_p1[k] : m_p0[k]};
    return '0;
  endfunction

  function automatic bit [20:0] u_look(int s, bit [31:0] va, bit [7:0] asid);
    for (int e = 0; e < 3; e++)
      if (mu_v[s][e] && mu_vpn[s][e] == va[31:12] && mu_asid[s][e] == asid)
        return {1'b1, mu_ppn[s][e]};
    return '0;
  endfunction

  function automatic void u_fill(int s, bit [31:0] va, bit [7:0] asid, bit [19:0] ppn);
    mu_vpn[s][mu_rr[s]]  = va[31:12];
    mu_asid[s][mu_rr[s]] = asid;
    mu_ppn[s][mu_rr[s]]  = ppn;
    mu_v[s][mu_rr[s]]    = 1'b1;
    mu_rr[s] = (mu_rr[s] == 2) ? 0 : mu_rr[s] + 1;
  endfunction

  function automatic void u_flush();
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 3; e++) mu_v[s][e] = 1'b0;
  endfunction

  function automatic logic [2:0] flags(int s);
    return s ? {d_hit, d_stall, d_miss} : {i_hit, i_stall, i_miss};
  endfunction

  function automatic logic [31:0] pa_of(int s);
    return s ? d_pa : i_pa;
  endfunction

  task automatic idle();
    i_req = 0; d_req = 0; d_pref = 0; jw_en = 0; inval_all = 0;
  endtask

  task automatic lookup(int s, bit [31:0] va, bit [7:0] asid, bit pref, string tag);
    bit [20:0] u, j;
    u = u_look(s, va, asid);
    j = j_look(va, asid);
    @(negedge clk);
    if (s == 0) begin i_req = 1; i_va = va; i_asid = asid; end
    else begin d_req = 1; d_va = va; d_asid = asid; d_pref = pref; end
    #2;
    if (u[20]) begin
      chk({tag, " first-level hit"}, flags(s), 3'b100);
      chk({tag, " pa"}, pa_of(s), {u[19:0], va[11:0]});
    end else begin
      chk({tag, " stall"}, flags(s), 3'b010);
      @(negedge clk); #2;
      if (j[20]) begin
        chk({tag, " refill hit"}, flags(s), 3'b100);
        chk({tag, " pa"}, pa_of(s), {j[19:0], va[11:0]});
        u_fill(s, va, asid, j[19:0]);
      end else if (s == 1 && pref) begin
        chk({tag, " prefetch dropped"}, flags(s), 3'b000);
        chk({tag, " pa zero"}, pa_of(s), 32'h0);
      end else begin
        chk({tag, " miss"}, flags(s), 3'b001);
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic jwrite(bit inv, bit wr, bit [3:0] idx, bit [18:0] vpn2, bit [7:0] asid,
                        bit [19:0] p0, bit v0, bit [19:0] p1, bit v1);
    @(negedge clk);
    inval_all = inv; jw_en = wr; jw_idx = idx; jw_vpn2 = vpn2; jw_asid = asid;
    jw_pfn0 = p0; jw_v0 = v0; jw_pfn1 = p1; jw_v1 = v1;
    @(negedge clk);
    idle();
    if (inv) for (int k = 0; k < 16; k++) begin m_v0[k] = 0; m_v1[k] = 0; end
    if (wr) begin
      m_vpn2[idx] = vpn2; m_asid[idx] = asid;
      m_p0[idx] = p0; m_v0[idx] = v0; m_p1[idx] = p1; m_v1[idx] = v1;
    end
    u_flush();
  endtask

  localparam bit [18:0] PX = 19'h0A5A5;
  localparam bit [18:0] PY = 19'h01234;
  localparam bit [18:0] PZ = 19'h07777;

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; idle();
    i_va = 0; d_va = 0; i_asid = 0; d_asid = 0;
    jw_idx = 0; jw_vpn2 = 0; jw_asid = 0; jw_pfn0 = 0; jw_pfn1 = 0; jw_v0 = 0; jw_v1 = 0;
    mu_rr[0] = 0; mu_rr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R11 idle outputs", {i_hit, i_stall, i_miss, d_hit, d_stall, d_miss}, 6'b0);
    chk("R11 idle pa", {i_pa, d_pa}, 64'h0);
    lookup(0, {PX, 1'b0, 12'h123}, 8'd5, 0, "R11 R4 empty after reset");

    jwrite(0, 1, 4'd3, PX, 8'd5, 20'h11111, 1, 20'h22222, 1);
    jwrite(0, 1, 4'd4, PY, 8'd5, 20'h33333, 1, 20'h44444, 0);
    jwrite(0, 1, 4'd5, PZ, 8'd5, 20'h55555, 1, 20'h66666, 1);
    lookup(0, {PX, 1'b0, 12'h0F0}, 8'd5, 0, "R2 R3 even refill");
    lookup(0, {PX, 1'b0, 12'hABC}, 8'd5, 0, "R1 repeat hit");
    lookup(1, {PX, 1'b0, 12'h001}, 8'd5, 0, "R7 data side separate");
    lookup(0, {PX, 1'b1, 12'h777}, 8'd5, 0, "R3 odd half");
    lookup(0, {PX, 1'b0, 12'h777}, 8'd6, 0, "R3 R4 id mismatch");
    lookup(1, {PY, 1'b1, 12'h010}, 8'd5, 0, "R4 invalid half");
    lookup(1, {PY, 1'b1, 12'h020}, 8'd5, 1, "R5 prefetch miss");
    lookup(1, {PY, 1'b0, 12'h030}, 8'd5, 1, "R5 prefetch hit");
    lookup(1, {PY, 1'b0, 12'h040}, 8'd5, 1, "R5 prefetch repeat");

    lookup(1, {PX, 1'b1, 12'h100}, 8'd5, 0, "R6 fill a");
    lookup(1, {PZ, 1'b0, 12'h200}, 8'd5, 0, "R6 fill b");
    lookup(1, {PZ, 1'b1, 12'h300}, 8'd5, 0, "R6 fill c");
    lookup(1, {PY, 1'b0, 12'h400}, 8'd5, 0, "R6 oldest evicted");
    lookup(1, {PZ, 1'b1, 12'h500}, 8'd5, 0, "R6 newer kept");

    jwrite(0, 1, 4'd9, 19'h00042, 8'd1, 20'h0, 0, 20'h0, 0);
    lookup(0, {PX, 1'b0, 12'h0F0}, 8'd5, 0, "R9 flushed by write");
    jwrite(0, 1, 4'd3, PX, 8'd5, 20'h99999, 1, 20'h22222, 1);
    lookup(0, {PX, 1'b0, 12'h0F0}, 8'd5, 0, "R9 rewritten frame");
    jwrite(0, 1, 4'd2, PX, 8'd5, 20'hBBBBB, 1, 20'h0, 0);
    lookup(1, {PX, 1'b0, 12'h0F0}, 8'd5, 0, "R3 lowest index wins");

    jwrite(0, 1, 4'd9, 19'h00042, 8'd1, 20'h0, 0, 20'h0, 0);
    @(negedge clk);
    i_req = 1; i_va = {PZ, 1'b0, 12'hAAA}; i_asid = 8'd5;
    d_req = 1; d_va = {PX, 1'b1, 12'hBBB}; d_asid = 8'd5; d_pref = 0;
    #2;
    chk("R8 both stall", {flags(0), flags(1)}, 6'b010010);
    @(negedge clk); #2;
    chk("R8 data first", {flags(0), flags(1)}, 6'b010100);
    chk("R8 data pa", d_pa, {20'h22222, 12'hBBB});
    @(negedge clk); #2;
    chk("R8 instr next", {flags(0), flags(1)}, 6'b100100);
    chk("R8 instr pa", i_pa, {20'h55555, 12'hAAA});
    u_fill(1, {PX, 1'b1, 12'h0}, 8'd5, 20'h22222);
    u_fill(0, {PZ, 1'b0, 12'h0}, 8'd5, 20'h55555);
    @(negedge clk); idle();

    jwrite(1, 1, 4'd7, PY, 8'd9, 20'hCCCCC, 1, 20'hDDDDD, 1);
    lookup(0, {PZ, 1'b0, 12'hAAA}, 8'd5, 0, "R10 invalidated");
    lookup(1, {PY, 1'b1, 12'h001}, 8'd9, 0, "R10 same-cycle write kept");

    for (int n = 0; n < 400; n++) begin
      int op;
      bit [18:0] vp;
      op = $urandom % 20;
      vp = 19'h10000 + 19'($urandom % 6);
      if (op < 2)
        jwrite(0, 1, 4'($urandom % 16), vp, 8'(1 + $urandom % 2), 20'($urandom),
               1'($urandom), 20'($urandom), 1'($urandom));
      else if (op == 2 && n % 7 == 0)
        jwrite(1, 0, 4'd0, 19'h0, 8'h0, 20'h0, 0, 20'h0, 0);
      else begin
        int s;
        s = $urandom % 2;
        lookup(s, {vp, 1'($urandom), 12'($urandom)}, 8'(1 + $urandom % 2),
               (s == 1) && ($urandom % 4 == 0), "R1 R2 R5 random");
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule